// File: doc/BRIEF.md
# SDRAM Low-Power Command Sequencer

This block turns 4-bit command codes written by software into single SDRAM command cycles on the memory pins. It also tracks whether the memory is active, in self-refresh or in deep-power-down. Each written code is checked against the current power state and against the codes accepted just before it.

A code that fits is issued one clock after the write, for exactly one cycle. A code that does not fit is dropped: no command reaches the pins, and a sticky error flag is raised. Deep-power-down entry must follow a precharge-all directly. Self-refresh entry must follow a precharge-all and then a NOP. While the memory is in either low-power state, clock enable is held low. The only code accepted in that state is the exit code for that same state.

Software uses the block by writing codes one at a time. It reads the power state and the error flag to confirm progress. Only a reset clears the error flag.

Top module: `lp_cmd_sequencer`

## Requirements
- R1: After reset, `pwr_state` is 00 (active), `mem_cke` is 1, all four command pins are 1 (deselect) and `seq_err` is 0.
- R2: In the active state, code 0 issues a NOP and code 1 issues a precharge-all. The NOP is {cs_n,ras_n,cas_n,we_n}=0111 and the precharge-all is 0010. Either appears in the cycle after the write and lasts one cycle.
- R3: In every cycle that does not follow a write, the pins show deselect (1111). No write has any effect on `mem_cke` or `pwr_state` apart from the transitions listed in R4 to R6.
- R4: In the active state, code 5 is accepted only when the two writes just before it were an accepted code 1 and then an accepted code 0. When accepted, it issues 0001 with `mem_cke` low, and `pwr_state` becomes 01 (self-refresh).
- R5: In the active state, code 3 is accepted only when the write just before it was an accepted code 1. When accepted, it issues 0110 with `mem_cke` low, and `pwr_state` becomes 10 (deep-power-down).
- R6: Code 6 in self-refresh and code 4 in deep-power-down each issue a NOP (0111) with `mem_cke` high, and return `pwr_state` to 00.
- R7: In either low-power state, every code other than that state's exit code is rejected. A rejected code raises `seq_err`, issues nothing (deselect), and leaves `pwr_state` and `mem_cke` unchanged.
- R8: Codes 2 and 7 to 15 are unused. In every state they are rejected in the same way as in R7.
- R9: In the active state, code 5 or code 3 without the required preparation is rejected, and so are the exit codes 4 and 6. Each is handled as in R7.
- R10: `seq_err` stays 1 from the first rejected write until reset, whatever is written afterwards.
- R11: A rejected write breaks the preparation chain. So does a repeated NOP. A following entry code is then rejected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_wr | input | 1 | Write strobe for the command code |
| cmd_code | input | CODE_W | Command code written by software |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_ras_n | output | 1 | Row strobe, active low |
| mem_cas_n | output | 1 | Column strobe, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_cke | output | 1 | Clock enable |
| pwr_state | output | 2 | 00 active, 01 self-refresh, 10 deep-power-down |
| seq_err | output | 1 | Sticky sequence-error flag |

## Verification
On every cycle, the assertions check four things:
- clock enable agrees with the power state;
- the error flag never falls;
- a cycle with no write leaves the pins deselected and holds a low-power state;
- an unprepared self-refresh entry always ends in an error with the state unchanged.

Several behaviours depend on the write history and on how each code lines up with each state, so only the bench's scenarios can show them. These are the exact pin patterns per code, the prepare chain of one or two preceding writes, and the rejection of every non-exit code from each low-power state. The bench sweeps all sixteen codes from every state and history.

// File: rtl/lp_cmd_sequencer.sv
module lp_cmd_sequencer #(
  parameter int CODE_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_wr,
  input  logic [CODE_W-1:0] cmd_code,
  output logic              mem_cs_n,
  output logic              mem_ras_n,
  output logic              mem_cas_n,
  output logic              mem_we_n,
  output logic              mem_cke,
  output logic [1:0]        pwr_state,
  output logic              seq_err
);
  localparam logic [CODE_W-1:0] C_NOP    = CODE_W'(0);
  localparam logic [CODE_W-1:0] C_PREALL = CODE_W'(1);
  localparam logic [CODE_W-1:0] C_DPD_IN = CODE_W'(3);
  localparam logic [CODE_W-1:0] C_DPD_EX = CODE_W'(4);
  localparam logic [CODE_W-1:0] C_SR_IN  = CODE_W'(5);
  localparam logic [CODE_W-1:0] C_SR_EX  = CODE_W'(6);

  localparam logic [1:0] ST_ACT = 2'b00;
  localparam logic [1:0] ST_SR  = 2'b01;
  localparam logic [1:0] ST_DPD = 2'b10;

  localparam logic [3:0] P_DESEL = 4'b1111;
  localparam logic [3:0] P_NOP   = 4'b0111;
  localparam logic [3:0] P_PRE   = 4'b0010;
  localparam logic [3:0] P_SREF  = 4'b0001;
  localparam logic [3:0] P_DPD   = 4'b0110;

  logic [1:0] st_q, st_n;
  logic [3:0] pin_q, pin_n;
  logic       cke_q, cke_n;
  logic       err_q;
  logic       pre_q, prenop_q;
  logic       ok;

  always_comb begin
    ok    = 1'b0;
    st_n  = st_q;
    pin_n = P_DESEL;
    cke_n = cke_q;
    if (cmd_wr) begin
      unique case (st_q)
        ST_ACT: begin
          if (cmd_code == C_NOP) begin
            ok = 1'b1; pin_n = P_NOP;
          end else if (cmd_code == C_PREALL) begin
            ok = 1'b1; pin_n = P_PRE;
          end else if (cmd_code == C_SR_IN && prenop_q) begin
            ok = 1'b1; pin_n = P_SREF; st_n = ST_SR; cke_n = 1'b0;
          end else if (cmd_code == C_DPD_IN && pre_q) begin
            ok = 1'b1; pin_n = P_DPD; st_n = ST_DPD; cke_n = 1'b0;
          end
        end
        ST_SR: begin
          if (cmd_code == C_SR_EX) begin
            ok = 1'b1; pin_n = P_NOP; st_n = ST_ACT; cke_n = 1'b1;
          end
        end
        ST_DPD: begin
          if (cmd_code == C_DPD_EX) begin
            ok = 1'b1; pin_n = P_NOP; st_n = ST_ACT; cke_n = 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q     <= ST_ACT;
      pin_q    <= P_DESEL;
      cke_q    <= 1'b1;
      err_q    <= 1'b0;
      pre_q    <= 1'b0;
      prenop_q <= 1'b0;
    end else begin
      st_q  <= st_n;
      pin_q <= pin_n;
      cke_q <= cke_n;
      if (cmd_wr && !ok) err_q <= 1'b1;
      if (cmd_wr) begin
        pre_q    <= ok && (cmd_code == C_PREALL) && (st_q == ST_ACT);
        prenop_q <= ok && (cmd_code == C_NOP) && pre_q;
      end
    end
  end

  assign {mem_cs_n, mem_ras_n, mem_cas_n, mem_we_n} = pin_q;
  assign mem_cke   = cke_q;
  assign pwr_state = st_q;
  assign seq_err   = err_q;

  a_r6_cke_matches_state: assert property (@(posedge clk) disable iff (!rst_n)
    mem_cke == (pwr_state == ST_ACT));

  a_r10_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    seq_err |=> seq_err);

  a_r3_idle_deselect: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_wr |=> mem_cs_n);

  a_r7_lowpower_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_state != ST_ACT && !cmd_wr) |=> $stable(pwr_state));

  a_r9_unprepared_sr: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && pwr_state == ST_ACT && cmd_code == C_SR_IN && !prenop_q)
      |=> (seq_err && pwr_state == ST_ACT && mem_cs_n));

  a_r4_sr_from_active: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_state == ST_SR) |=> (pwr_state == ST_SR || pwr_state == ST_ACT));
endmodule

// File: tb/test_lp_cmd_sequencer.sv
module test_lp_cmd_sequencer;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 100000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_wr = 1'b0;
  logic [3:0] cmd_code = 4'h0;
  logic cs_n, ras_n, cas_n, we_n, cke, err;
  logic [1:0] pst;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lp_cmd_sequencer #(.CODE_W(4)) i_lp_cmd_sequencer (
    .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_code(cmd_code),
    .mem_cs_n(cs_n), .mem_ras_n(ras_n), .mem_cas_n(cas_n), .mem_we_n(we_n),
    .mem_cke(cke), .pwr_state(pst), .seq_err(err));

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG) begin
      fails++;
      $display("FAIL watchdog: actual %0d cycles, expected below %0d", cycles, WATCHDOG);
      summary();
    end
  end

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic chk_all(input string tag, input logic [3:0] ep, input bit ecke,
                         input logic [1:0] est, input bit eerr);
    chk(tag, "pins", {cs_n, ras_n, cas_n, we_n}, ep);
    chk(tag, "cke", cke, ecke);
    chk(tag, "state", pst, est);
    chk(tag, "err", err, eerr);
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0; cmd_wr = 1'b0;
    @(negedge clk); @(negedge clk); rst_n = 1'b1;
  endtask

  task automatic wr(input logic [3:0] c);
    @(negedge clk); cmd_wr = 1'b1; cmd_code = c;
    @(negedge clk); cmd_wr = 1'b0;
  endtask

  task automatic model(input logic [1:0] s, input int h, input logic [3:0] c,
                       output logic [3:0] p, output bit k, output logic [1:0] ns,
                       output bit e, output string tag);
    p = 4'hF; ns = s; k = (s == 2'b00); e = 1'b1;
    tag = (c == 4'd2 || c > 4'd6) ? "R8" : (s != 2'b00 ? "R7" : "R9");
    if (s == 2'b00) begin
      if (c == 4'd0) begin p = 4'b0111; e = 0; tag = "R2"; end
      else if (c == 4'd1) begin p = 4'b0010; e = 0; tag = "R2"; end
      else if (c == 4'd5 && h == 2) begin p = 4'b0001; ns = 2'b01; k = 0; e = 0; tag = "R4"; end
      else if (c == 4'd3 && h == 1) begin p = 4'b0110; ns = 2'b10; k = 0; e = 0; tag = "R5"; end
    end else if ((s == 2'b01 && c == 4'd6) || (s == 2'b10 && c == 4'd4)) begin
      p = 4'b0111; ns = 2'b00; k = 1; e = 0; tag = "R6";
    end
  endtask

  initial begin
    logic [3:0] ep; bit ek; logic [1:0] es; bit ee; string tag;
    do_reset();
    chk_all("R1", 4'hF, 1'b1, 2'b00, 1'b0);

    for (int s = 0; s < 3; s++) begin
      for (int h = 0; h < 3; h++) begin
        if (s != 0 && h != 0) continue;
        for (int c = 0; c < 16; c++) begin
          do_reset();
          if (s == 1) begin wr(4'd1); wr(4'd0); wr(4'd5); end
          if (s == 2) begin wr(4'd1); wr(4'd3); end
          if (h >= 1) wr(4'd1);
          if (h == 2) wr(4'd0);
          @(negedge clk);
          chk("R3", "idle pins", {cs_n, ras_n, cas_n, we_n}, 4'hF);
          model(2'(s), h, 4'(c), ep, ek, es, ee, tag);
          wr(4'(c));
          chk_all(tag, ep, ek, es, ee);
          @(negedge clk);
          chk("R3", "deselect after", {cs_n, ras_n, cas_n, we_n}, 4'hF);
          chk(tag, "state held", pst, es);
          if (ee) begin
            wr(es == 2'b01 ? 4'd6 : (es == 2'b10 ? 4'd4 : 4'd0));
            chk("R10", "err sticky", err, 1);
          end
        end
      end
    end

    do_reset();
    wr(4'd1); wr(4'd0); wr(4'd0); wr(4'd5);
    chk_all("R11", 4'hF, 1'b1, 2'b00, 1'b1);
    do_reset();
    wr(4'd1); wr(4'd2); wr(4'd3);
    chk_all("R11", 4'hF, 1'b1, 2'b00, 1'b1);
    do_reset();
    wr(4'd1); wr(4'd3); wr(4'd4); wr(4'd1); wr(4'd0); wr(4'd5);
    chk_all("R4", 4'b0001, 1'b0, 2'b01, 1'b0);

    summary();
  end
endmodule